// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command front end of a flash memory that programs words in bursts. A host on a simple synchronous bus opens a burst with a setup command. It then writes a word count, the data words, and a confirm command. The sequencer collects the words in a write buffer. On a valid confirm it hands them to an array-programming engine. The engine stays busy for a fixed number of clock cycles and merges each buffered word into consecutive array locations. Programming can only clear bits, so a stored word becomes `old & new`.

A status register reports whether the engine is idle and carries three sticky error flags. The burst is rejected, and the array left untouched, in four cases: the count is too large, the confirm code is wrong, the range would leave its erase block, or the programming-voltage input is at lockout. Each rejection raises a defined pair of error bits. The bits stay set until the host writes a clear-status command. Host reads return either array contents or the status register, depending on the read mode last selected and on whether the engine is busy.

Top module: `fbp_seq`

## Requirements
- R1: After reset the status register reads 0x0080, and reads return status. Status sits in the low byte of the read data with the upper byte zero. Bit 7 is ready, bit 5 is the sequence error, bit 4 is the program error, and bit 3 is the voltage error.
- R2: A burst is a setup write (low byte 0xE8, whose address becomes the base), a count write holding N-1, N data writes, and a confirm write (low byte 0xD0). When it is accepted, word k becomes `old & data_k` at address base+k. Voltage levels 1 and 2 are both accepted.
- R3: From the edge that takes an accepted confirm, the engine is busy for PROG_CYC cycles. During that time status bit 7 reads 0 and every read returns the status register. Afterwards bit 7 reads 1 again.
- R4: If (base mod BLK_WORDS) + N - 1 >= BLK_WORDS, the confirm sets bits 5 and 4 and writes nothing. This check takes priority over the voltage check. A burst that ends exactly on the last word of its block is accepted.
- R5: A confirm taken while the voltage input is 0 (lockout) sets bits 4 and 3 and writes nothing.
- R6: A count word whose value exceeds BUF_WORDS-1 aborts the burst at once with bits 5 and 4 set.
- R7: A confirm word whose low byte is not 0xD0 aborts the burst with bits 5 and 4 set and writes nothing.
- R8: Error bits stay set across later successful bursts. Only a clear-status write (low byte 0x50) while idle clears them.
- R9: Once a burst has finished, data or confirm writes sent without a new setup change neither the array nor the status.
- R10: A read-array write (0xFF) makes later idle reads return array words. A read-status write (0x70) or a setup makes them return status. Every read is answered one cycle later with the read-valid output high.
- R11: Writes issued while the engine is busy are ignored, including setup and read-array commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce | input | 1 | Chip enable; qualifies reads and writes |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | DW (16) | Write data or command (low byte) |
| vpp_lvl | input | 2 | Programming voltage: 0 lockout, 1 low, 2 or 3 high |
| bus_rdata | output | DW (16) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |

## Verification
Several cases get targeted tests. One is a burst ending on the last word of an erase block next to one crossing it: a wrong comparison either rejects a legal burst or corrupts the next block. Another is a burst that breaks both the boundary and voltage rules, where swapped priority shows 0x98 instead of 0xB0. The bench also reprograms over existing words, so a design that stores data without AND-merging returns the new pattern. A successful burst runs while an error is pending, so clearing on success is caught. Commands sent during busy must leave the read mode unchanged, and stray confirm or data words after a finished burst must not start a second program.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam logic [7:0] CMD_SETUP     = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_CLEAR     = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;

  localparam logic [1:0] VPP_LOCKOUT   = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_BUSY
  } seq_state_e;

endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
  parameter int DW     = 16,
  parameter int ADDR_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     q
);

  logic [DW-1:0] mem [WORDS];

  // erased state: all ones
  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end

endmodule

// File: rtl/fbp_cmd_fsm.sv
module fbp_cmd_fsm
  import fbp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_WORDS = 64,
  localparam int BIDX_W   = $clog2(BUF_WORDS),
  localparam int BOFF_W   = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        vpp_lvl,
  input  logic              eng_done,
  output logic              buf_we,
  output logic [BIDX_W-1:0] buf_widx,
  output logic              eng_start,
  output logic [ADDR_W-1:0] eng_base,
  output logic [BIDX_W-1:0] eng_last,
  output logic [7:0]        sr,
  output logic              rd_stat
);

  seq_state_e        st_q;
  logic [ADDR_W-1:0] base_q;
  logic [BIDX_W-1:0] last_q;
  logic [BIDX_W-1:0] idx_q;
  logic              err_seq_q, err_prog_q, err_vpp_q;
  logic              rd_stat_q;

  logic [7:0]    cmd;
  logic          cnt_bad;
  logic [BOFF_W:0] end_off;
  logic          crosses;
  logic          conf_ok;

  assign cmd     = wr_data[7:0];
  assign cnt_bad = wr_data > DW'(BUF_WORDS - 1);
  assign end_off = {1'b0, base_q[BOFF_W-1:0]} + (BOFF_W+1)'(last_q);
  assign crosses = end_off >= (BOFF_W+1)'(BLK_WORDS);
  assign conf_ok = (cmd == CMD_CONFIRM) && !crosses && (vpp_lvl != VPP_LOCKOUT);

  assign buf_we    = wr_en && (st_q == ST_DATA);
  assign buf_widx  = idx_q;
  assign eng_start = wr_en && (st_q == ST_CONFIRM) && conf_ok;
  assign eng_base  = base_q;
  assign eng_last  = last_q;
  assign rd_stat   = rd_stat_q;
  assign sr        = {st_q != ST_BUSY, 1'b0, err_seq_q, err_prog_q, err_vpp_q, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      base_q     <= '0;
      last_q     <= '0;
      idx_q      <= '0;
      err_seq_q  <= 1'b0;
      err_prog_q <= 1'b0;
      err_vpp_q  <= 1'b0;
      rd_stat_q  <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_en) begin
            if (cmd == CMD_SETUP) begin
              base_q    <= wr_addr;
              rd_stat_q <= 1'b1;
              st_q      <= ST_COUNT;
            end else if (cmd == CMD_CLEAR) begin
              err_seq_q  <= 1'b0;
              err_prog_q <= 1'b0;
              err_vpp_q  <= 1'b0;
            end else if (cmd == CMD_RD_ARRAY) begin
              rd_stat_q <= 1'b0;
            end else if (cmd == CMD_RD_STATUS) begin
              rd_stat_q <= 1'b1;
            end
          end
        end
        ST_COUNT: begin
          if (wr_en) begin
            if (cnt_bad) begin
              err_seq_q  <= 1'b1;
              err_prog_q <= 1'b1;
              st_q       <= ST_IDLE;
            end else begin
              last_q <= wr_data[BIDX_W-1:0];
              idx_q  <= '0;
              st_q   <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (wr_en) begin
            idx_q <= idx_q + BIDX_W'(1);
            if (idx_q == last_q) st_q <= ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (wr_en) begin
            if ((cmd != CMD_CONFIRM) || crosses) begin
              err_seq_q  <= 1'b1;
              err_prog_q <= 1'b1;
              st_q       <= ST_IDLE;
            end else if (vpp_lvl == VPP_LOCKOUT) begin
              err_prog_q <= 1'b1;
              err_vpp_q  <= 1'b1;
              st_q       <= ST_IDLE;
            end else begin
              st_q <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (eng_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbp_prog_engine.sv
module fbp_prog_engine #(
  parameter int ADDR_W    = 8,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int PROG_CYC  = 80,
  localparam int BIDX_W   = $clog2(BUF_WORDS),
  localparam int CYC_W    = $clog2(PROG_CYC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [BIDX_W-1:0] last,
  output logic [BIDX_W-1:0] buf_raddr,
  input  logic [DW-1:0]     buf_rdata,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_we,
  output logic [DW-1:0]     arr_wdata,
  input  logic [DW-1:0]     arr_q,
  output logic              busy,
  output logic              done
);

  // two cycles per word (read, then merge-write) must fit in the busy window
  if (PROG_CYC < 2 * BUF_WORDS + 1) begin : g_bad_cyc
    initial $error("PROG_CYC too small for BUF_WORDS");
  end

  logic             active_q;
  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-2:0] word_idx;
  logic             in_rng;

  assign word_idx  = cyc_q[CYC_W-1:1];
  assign in_rng    = active_q && (word_idx <= (CYC_W-1)'(last));
  assign buf_raddr = word_idx[BIDX_W-1:0];
  assign arr_addr  = base + ADDR_W'(word_idx);
  assign arr_we    = in_rng && cyc_q[0];
  assign arr_wdata = arr_q & buf_rdata;
  assign done      = active_q && (cyc_q == CYC_W'(PROG_CYC - 1));
  assign busy      = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cyc_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cyc_q    <= '0;
    end else if (active_q) begin
      if (done) active_q <= 1'b0;
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq #(
  parameter int ADDR_W    = 8,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_WORDS = 64,
  parameter int PROG_CYC  = 80,
  localparam int BIDX_W   = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ce,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [1:0]        vpp_lvl,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid
);

  logic              wr_en, rd_req;
  logic              buf_we;
  logic [BIDX_W-1:0] buf_widx, buf_raddr;
  logic [DW-1:0]     buf_rdata;
  logic              eng_start, eng_busy, eng_done;
  logic [ADDR_W-1:0] eng_base, eng_addr, arr_addr;
  logic [BIDX_W-1:0] eng_last;
  logic              arr_we;
  logic [DW-1:0]     arr_wdata, arr_q;
  logic [7:0]        sr;
  logic              rd_stat;

  logic              rvalid_q, rsel_q;
  logic [7:0]        stat_q;

  assign wr_en  = bus_ce && bus_we;
  assign rd_req = bus_ce && bus_re;

  fbp_cmd_fsm #(
    .ADDR_W(ADDR_W), .DW(DW), .BUF_WORDS(BUF_WORDS), .BLK_WORDS(BLK_WORDS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata), .vpp_lvl(vpp_lvl),
    .eng_done(eng_done),
    .buf_we(buf_we), .buf_widx(buf_widx),
    .eng_start(eng_start), .eng_base(eng_base), .eng_last(eng_last),
    .sr(sr), .rd_stat(rd_stat)
  );

  fbp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_wbuf (
    .clk(clk), .we(buf_we), .waddr(buf_widx), .wdata(bus_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  fbp_prog_engine #(
    .ADDR_W(ADDR_W), .DW(DW), .BUF_WORDS(BUF_WORDS), .PROG_CYC(PROG_CYC)
  ) u_eng (
    .clk(clk), .rst(rst),
    .start(eng_start), .base(eng_base), .last(eng_last),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .arr_addr(eng_addr), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_q(arr_q),
    .busy(eng_busy), .done(eng_done)
  );

  assign arr_addr = eng_busy ? eng_addr : bus_addr;

  fbp_array #(.DW(DW), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .addr(arr_addr), .we(arr_we), .wdata(arr_wdata), .q(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rsel_q   <= 1'b1;
      stat_q   <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        rsel_q <= rd_stat || eng_busy;
        stat_q <= sr;
      end
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rsel_q ? {{(DW-8){1'b0}}, stat_q} : arr_q;

endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ce,
  input logic          bus_we,
  input logic          bus_re,
  input logic [7:0]    cmd_byte,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_rvalid,
  input logic [7:0]    sr,
  input logic          eng_busy
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !sr[7]); // R3

  AST_BUSY_READ_STATUS: assert property (@(posedge clk) disable iff (rst)
    (bus_ce && bus_re && eng_busy) |=> (bus_rvalid && !bus_rdata[7])); // R3

  AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> sr[7]); // R3

  AST_SEQ_ERR_PAIR: assert property (@(posedge clk) disable iff (rst)
    sr[5] |-> sr[4]); // R4

  AST_VPP_ERR_PAIR: assert property (@(posedge clk) disable iff (rst)
    sr[3] |-> sr[4]); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sr[4] && !(bus_ce && bus_we && cmd_byte == 8'h50)) |=> sr[4]); // R8

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (bus_ce && bus_re) |=> bus_rvalid); // R10

endmodule

bind fbp_seq fbp_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_we(bus_we), .bus_re(bus_re),
  .cmd_byte(bus_wdata[7:0]), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .sr(sr), .eng_busy(eng_busy)
);

// File: tb/fbp_seq_tb.sv
module fbp_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DW         = 16;
  localparam int BUF_WORDS  = 32;
  localparam int BLK_WORDS  = 64;
  localparam int PROG_CYC   = 80;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_ce = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [1:0]        vpp_lvl = 2'd1;
  logic [DW-1:0]     bus_rdata;
  logic              bus_rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbp_seq #(
    .ADDR_W(ADDR_W), .DW(DW), .BUF_WORDS(BUF_WORDS),
    .BLK_WORDS(BLK_WORDS), .PROG_CYC(PROG_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .vpp_lvl(vpp_lvl),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  logic [DW-1:0] model [1 << ADDR_W];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  int            checks = 0;
  int            errors = 0;
  bit            reported = 1'b0;

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '1;
  end

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: actual %h expected no read", bus_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e)
          begin errors++; $display("FAIL %s: actual %h expected %h", t, bus_rdata, e); end
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_ce = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_ce = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_ce = 1'b1; bus_re = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_ce = 1'b0; bus_re = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input logic [DW-1:0] seed, input int k);
    return seed ^ {k[7:0], ~k[7:0]};
  endfunction

  // full burst; model updated only when the requirements say it is accepted
  task automatic burst(input int base, input int n, input logic [DW-1:0] seed,
                       input logic [1:0] vpp, input logic [DW-1:0] conf);
    bit ok;
    ok = (conf[7:0] == 8'hD0) && ((base % BLK_WORDS) + n - 1 < BLK_WORDS) && (vpp != 2'd0);
    vpp_lvl = vpp;
    bus_write(base, 16'h00E8);
    bus_write(base, DW'(n - 1));
    for (int k = 0; k < n; k++) bus_write(base, pat(seed, k));
    bus_write(base, conf);
    if (ok)
      for (int k = 0; k < n; k++) model[base + k] = model[base + k] & pat(seed, k);
  endtask

  task automatic wait_done();
    repeat (PROG_CYC + 4) @(negedge clk);
  endtask

  task automatic check_words(input int base, input int n, input string t);
    for (int k = 0; k < n; k++) bus_read(base + k, model[base + k], t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    bus_read(0, 16'h0080, "R1 reset status");

    bus_write(0, 16'h00FF);
    bus_read(5, 16'hFFFF, "R10 read array mode");

    // accepted burst at low voltage level
    burst(8, 4, 16'hA5F0, 2'd1, 16'h00D0);
    bus_read(0, 16'h0000, "R3 busy status");
    bus_read(8, 16'h0000, "R3 busy read returns status");
    wait_done();
    bus_read(0, 16'h0080, "R3 ready again");
    bus_write(0, 16'h00FF);
    check_words(8, 5, "R2 first burst");

    // reprogram same words at high level: AND merge
    burst(8, 4, 16'h3C3C, 2'd2, 16'h00D0);
    wait_done();
    bus_write(0, 16'h00FF);
    check_words(8, 4, "R2 bits only clear");

    // full buffer and exact block fit
    burst(64, 32, 16'h5A00, 2'd2, 16'h00D0);
    wait_done();
    burst(160, 32, 16'h0F0F, 2'd3, 16'h00D0);
    wait_done();
    bus_write(0, 16'h00FF);
    bus_read(64, model[64], "R2 full buffer first");
    bus_read(95, model[95], "R2 full buffer last");
    bus_read(96, 16'hFFFF, "R2 word after buffer untouched");
    bus_read(191, model[191], "R4 exact block fit last word");

    // boundary crossing
    burst(40, 32, 16'h1111, 2'd2, 16'h00D0);
    bus_read(0, 16'h00B0, "R4 boundary abort status");
    bus_write(0, 16'h00FF);
    bus_read(40, 16'hFFFF, "R4 no write on abort");
    bus_read(63, 16'hFFFF, "R4 no write at block end");

    // sticky error across a good burst
    burst(180, 1, 16'h00F0, 2'd1, 16'h00D0);
    bus_read(0, 16'h0030, "R8 busy keeps errors");
    wait_done();
    bus_read(0, 16'h00B0, "R8 sticky after success");
    bus_write(0, 16'h00FF);
    bus_read(180, model[180], "R2 burst with errors pending");
    bus_write(0, 16'h0050);
    bus_write(0, 16'h0070);
    bus_read(0, 16'h0080, "R8 clear status");

    // voltage lockout
    burst(200, 2, 16'h0000, 2'd0, 16'h00D0);
    bus_read(0, 16'h0098, "R5 lockout status");
    bus_write(0, 16'h00FF);
    bus_read(200, 16'hFFFF, "R5 no write at lockout");
    bus_write(0, 16'h0050);

    // boundary and lockout together: boundary wins
    burst(62, 4, 16'h0000, 2'd0, 16'h00D0);
    bus_read(0, 16'h00B0, "R4 boundary over lockout");
    bus_write(0, 16'h0050);

    // oversize count
    vpp_lvl = 2'd1;
    bus_write(0, 16'h00E8);
    bus_write(0, DW'(BUF_WORDS + 8));
    bus_read(0, 16'h00B0, "R6 count too large");
    bus_write(0, 16'h0050);
    bus_read(0, 16'h0080, "R6 idle after clear");

    // wrong confirm
    burst(220, 2, 16'h0000, 2'd1, 16'h00AA);
    bus_read(0, 16'h00B0, "R7 bad confirm status");
    bus_write(0, 16'h00FF);
    bus_read(220, 16'hFFFF, "R7 no write on bad confirm");
    bus_write(0, 16'h0050);

    // stray words without setup
    bus_write(230, 16'h1234);
    bus_write(230, 16'h00D0);
    repeat (4) @(negedge clk);
    bus_write(0, 16'h00FF);
    bus_read(230, 16'hFFFF, "R9 no program without setup");
    bus_write(0, 16'h0070);
    bus_read(0, 16'h0080, "R9 status unchanged");

    // commands during busy are ignored
    burst(240, 1, 16'h00FF, 2'd1, 16'h00D0);
    bus_write(0, 16'h00FF);
    bus_write(0, 16'h00E8);
    wait_done();
    bus_read(0, 16'h0080, "R11 mode kept status");
    bus_write(0, 16'h0000);
    bus_write(0, 16'h00FF);
    bus_read(240, model[240], "R11 burst unaffected");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    report();
  end

endmodule